// File: doc/BRIEF.md
# Register Window Pointer Controller

This block keeps the current window pointer and the window invalid mask for a processor whose integer register file is split into a ring of overlapping windows. The number of windows is a parameter. Each cycle it accepts at most one command: move to the previous window (save), move to the next window (restore), return from trap, load the status word, or load the invalid mask. It computes the candidate pointer with wraparound and checks the candidate against the invalid mask. When a command cannot complete, it requests a trap and leaves its state as it was.

The block also packs its flags into a 32-bit status word and unpacks a written word into those flags. It presents the base offset of the active window in the register file, so the register file can add that offset to its local register index. A trap request is a single-cycle pulse with a 2-bit code. The trap handler and the register storage sit outside this block.

Top module: `regwin_ctrl`

## Requirements
- R1: After reset the pointer is 0, the invalid mask is all zero, the trap-enable bit is 0, the supervisor bit is 1, the previous-supervisor, float-enable, interrupt-level and condition-code fields are 0, and no trap pulse is present.
- R2: A save sets the pointer to the current pointer minus one, and to NWIN-1 when the current pointer is 0. The pointer always stays below NWIN.
- R3: A restore sets the pointer to the current pointer plus one, and to 0 when the current pointer is NWIN-1.
- R4: A save whose candidate pointer selects a set bit of the invalid mask raises trap code 1 (window overflow) and leaves the pointer unchanged.
- R5: A restore whose candidate pointer selects a set bit of the invalid mask raises trap code 2 (window underflow) and leaves the pointer unchanged.
- R6: A return-from-trap while the trap-enable bit is 1 raises trap code 3 (illegal) and changes no state.
- R7: A return-from-trap while the trap-enable bit is 0 moves the pointer as a restore does, sets the trap-enable bit and copies the previous-supervisor bit into the supervisor bit. If the candidate pointer is marked invalid, it raises code 2 and changes nothing.
- R8: A status write whose pointer field (bits 4:0) is NWIN or more raises trap code 3 and changes no state.
- R9: The status word holds the pointer in bits 4:0, trap-enable in bit 5, previous-supervisor in bit 6, supervisor in bit 7, the interrupt level in bits 11:8, float-enable in bit 12, the condition codes in bits 23:20 and the VERSION parameter in bits 31:24. All other bits read 0. A legal status write loads every writable field from the same positions.
- R10: The register base output equals the pointer times 16.
- R11: Command priority, from highest to lowest, is save, restore, return-from-trap, status write, mask write. When several strobes are high in one cycle, only the highest-priority command takes effect.
- R12: A mask write loads the invalid mask from the low NWIN bits of the write data.
- R13: The trap pulse is high for exactly the cycle after the failing command. The trap code is 0 whenever no pulse is present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| save_req | input | 1 | Move to the previous window |
| restore_req | input | 1 | Move to the next window |
| rett_req | input | 1 | Return from trap |
| wrsr_req | input | 1 | Load the status word from wr_data |
| wrwim_req | input | 1 | Load the invalid mask from wr_data |
| wr_data | input | 32 | Write data for the status and mask writes |
| cwp | output | 5 | Current window pointer |
| wim | output | NWIN | Window invalid mask |
| status_word | output | 32 | Packed status word |
| reg_base | output | 9 | Register-file base offset of the active window |
| trap_pulse | output | 1 | Single-cycle trap request |
| trap_code | output | 2 | 0 none, 1 overflow, 2 underflow, 3 illegal |

## Verification
Every output is registered one stage from the command. A wrong pointer, flag or mask therefore shows on cwp, reg_base, status_word or wim in the cycle right after the command that caused it. A pointer that wraps wrongly or a mask bit that is wrongly indexed does not always show at once. It shows on a later move into the window concerned, as a missing or spurious trap pulse. For that reason the bench compares every output on every cycle against a behavioural model, across long random command runs and directed walks around the full ring.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

   typedef enum logic [1:0] {
      TRAP_NONE    = 2'd0,
      TRAP_WOVF    = 2'd1,
      TRAP_WUNF    = 2'd2,
      TRAP_ILLEGAL = 2'd3
   } trap_e;

   localparam int CMD_COUNT = 5;
   localparam int CMD_SAVE  = 0;
   localparam int CMD_REST  = 1;
   localparam int CMD_RETT  = 2;
   localparam int CMD_WRSR  = 3;
   localparam int CMD_WRWIM = 4;

   localparam int PTR_W    = 5;
   localparam int WIN_REGS = 16;

   typedef struct packed {
      logic [3:0] icc;
      logic       ef;
      logic [3:0] pil;
      logic       s;
      logic       ps;
      logic       et;
   } flags_t;

endpackage

// File: rtl/wpc_cmd_arb.sv
module wpc_cmd_arb #(
   parameter int N = 5
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant
);
   for (genvar i = 0; i < N; i++) begin : g_slot
      if (i == 0) begin : g_top
         assign grant[i] = req[i];
      end else begin : g_lower
         assign grant[i] = req[i] & ~(|req[i-1:0]);
      end
   end
endmodule

// File: rtl/wpc_ptr_step.sv
module wpc_ptr_step #(
   parameter int NWIN = 8,
   parameter int W    = 5
) (
   input  logic [W-1:0] cur,
   output logic [W-1:0] up,
   output logic [W-1:0] down
);
   localparam logic [W-1:0] LAST = W'(NWIN - 1);
   localparam bit POW2 = ((NWIN & (NWIN - 1)) == 0);

   if (POW2) begin : g_pow2
      always_comb begin
         up   = (cur + 1'b1) & LAST;
         down = (cur - 1'b1) & LAST;
      end
   end else begin : g_cmp
      always_comb begin
         up   = (cur == LAST) ? '0 : cur + 1'b1;
         down = (cur == '0) ? LAST : cur - 1'b1;
      end
   end
endmodule

// File: rtl/wpc_psr_fmt.sv
module wpc_psr_fmt
   import wpc_pkg::*;
#(
   parameter logic [7:0] VERSION = 8'h10
) (
   input  logic [PTR_W-1:0] cur_ptr,
   input  flags_t           cur_flags,
   output logic [31:0]      word_out,
   input  logic [31:0]      word_in,
   output logic [PTR_W-1:0] in_ptr,
   output flags_t           in_flags
);
   assign word_out = {VERSION, cur_flags.icc, 7'b0, cur_flags.ef, cur_flags.pil,
                      cur_flags.s, cur_flags.ps, cur_flags.et, cur_ptr};

   assign in_ptr       = word_in[4:0];
   assign in_flags.et  = word_in[5];
   assign in_flags.ps  = word_in[6];
   assign in_flags.s   = word_in[7];
   assign in_flags.pil = word_in[11:8];
   assign in_flags.ef  = word_in[12];
   assign in_flags.icc = word_in[23:20];

   logic unused_fields;
   assign unused_fields = ^{word_in[31:24], word_in[19:13]};
endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
   import wpc_pkg::*;
#(
   parameter int         NWIN    = 8,
   parameter logic [7:0] VERSION = 8'h10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            save_req,
   input  logic            restore_req,
   input  logic            rett_req,
   input  logic            wrsr_req,
   input  logic            wrwim_req,
   input  logic [31:0]     wr_data,
   output logic [4:0]      cwp,
   output logic [NWIN-1:0] wim,
   output logic [31:0]     status_word,
   output logic [8:0]      reg_base,
   output logic            trap_pulse,
   output logic [1:0]      trap_code
);
   localparam int BASE_SH = $clog2(WIN_REGS);
   localparam logic [PTR_W:0] NWIN_X = (PTR_W + 1)'(NWIN);

   if (NWIN < 2 || NWIN > 32) begin : g_bad_nwin
      $error("regwin_ctrl: NWIN must lie in 2..32");
   end
   if (PTR_W + BASE_SH != 9) begin : g_bad_base
      $error("regwin_ctrl: base offset width mismatch");
   end

   logic [PTR_W-1:0]     cwp_q, cwp_n;
   logic [NWIN-1:0]      wim_q, wim_n;
   flags_t               flg_q, flg_n;
   logic                 trap_q, trap_n;
   trap_e                code_q, code_n;
   logic [CMD_COUNT-1:0] req, grant;
   logic [PTR_W-1:0]     ptr_up, ptr_down, wr_ptr;
   flags_t               wr_flags;
   logic [31:0]          wim_ext;

   assign req = {wrwim_req, wrsr_req, rett_req, restore_req, save_req};

   wpc_cmd_arb #(.N(CMD_COUNT)) u_arb (
      .req   (req),
      .grant (grant)
   );

   wpc_ptr_step #(.NWIN(NWIN), .W(PTR_W)) u_step (
      .cur  (cwp_q),
      .up   (ptr_up),
      .down (ptr_down)
   );

   wpc_psr_fmt #(.VERSION(VERSION)) u_fmt (
      .cur_ptr   (cwp_q),
      .cur_flags (flg_q),
      .word_out  (status_word),
      .word_in   (wr_data),
      .in_ptr    (wr_ptr),
      .in_flags  (wr_flags)
   );

   assign wim_ext = 32'(wim_q);

   always_comb begin
      cwp_n  = cwp_q;
      wim_n  = wim_q;
      flg_n  = flg_q;
      trap_n = 1'b0;
      code_n = TRAP_NONE;
      if (grant[CMD_SAVE]) begin
         if (wim_ext[ptr_down]) begin
            trap_n = 1'b1;
            code_n = TRAP_WOVF;
         end else begin
            cwp_n = ptr_down;
         end
      end else if (grant[CMD_REST]) begin
         if (wim_ext[ptr_up]) begin
            trap_n = 1'b1;
            code_n = TRAP_WUNF;
         end else begin
            cwp_n = ptr_up;
         end
      end else if (grant[CMD_RETT]) begin
         if (flg_q.et) begin
            trap_n = 1'b1;
            code_n = TRAP_ILLEGAL;
         end else if (wim_ext[ptr_up]) begin
            trap_n = 1'b1;
            code_n = TRAP_WUNF;
         end else begin
            cwp_n    = ptr_up;
            flg_n.et = 1'b1;
            flg_n.s  = flg_q.ps;
         end
      end else if (grant[CMD_WRSR]) begin
         if ({1'b0, wr_ptr} >= NWIN_X) begin
            trap_n = 1'b1;
            code_n = TRAP_ILLEGAL;
         end else begin
            cwp_n = wr_ptr;
            flg_n = wr_flags;
         end
      end else if (grant[CMD_WRWIM]) begin
         wim_n = wr_data[NWIN-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cwp_q  <= '0;
         wim_q  <= '0;
         flg_q  <= '{icc: 4'h0, ef: 1'b0, pil: 4'h0, s: 1'b1, ps: 1'b0, et: 1'b0};
         trap_q <= 1'b0;
         code_q <= TRAP_NONE;
      end else begin
         cwp_q  <= cwp_n;
         wim_q  <= wim_n;
         flg_q  <= flg_n;
         trap_q <= trap_n;
         code_q <= code_n;
      end
   end

   assign cwp        = cwp_q;
   assign wim        = wim_q;
   assign reg_base   = {cwp_q, BASE_SH'(0)};
   assign trap_pulse = trap_q;
   assign trap_code  = code_q;

   // Pointer stays inside the ring (R2)
   p_ptr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, cwp_q} < NWIN_X);

   p_save_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(grant[CMD_SAVE]) && !trap_q) |->
      (int'(cwp_q) == (($past(cwp_q) == 0) ? NWIN - 1 : int'($past(cwp_q)) - 1)));

   p_rest_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(grant[CMD_REST]) && !trap_q) |->
      (int'(cwp_q) == ((int'($past(cwp_q)) == NWIN - 1) ? 0 : int'($past(cwp_q)) + 1)));

   p_ovf_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_q && code_q == TRAP_WOVF) |-> (cwp_q == $past(cwp_q) && $past(grant[CMD_SAVE])));

   p_unf_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_q && code_q == TRAP_WUNF) |-> (cwp_q == $past(cwp_q) && flg_q == $past(flg_q)));

   p_ill_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_q && code_q == TRAP_ILLEGAL) |-> ($stable(status_word) && $stable(wim_q)));

   p_rett_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(grant[CMD_RETT]) && !trap_q) |-> (flg_q.et && flg_q.s == $past(flg_q.ps)));

   p_one_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   p_quiet_code_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_q |-> (code_q == TRAP_NONE));
endmodule

// File: tb/regwin_ctrl_test.sv
`timescale 1ns/1ps
module regwin_ctrl_test;
   localparam int         N   = 6;
   localparam logic [7:0] VER = 8'h35;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        save_req = 0, restore_req = 0, rett_req = 0, wrsr_req = 0, wrwim_req = 0;
   logic [31:0] wr_data = '0;
   logic [4:0]  cwp;
   logic [N-1:0] wim;
   logic [31:0] status_word;
   logic [8:0]  reg_base;
   logic        trap_pulse;
   logic [1:0]  trap_code;

   regwin_ctrl #(.NWIN(N), .VERSION(VER)) uut (
      .clk(clk), .rst_n(rst_n), .save_req(save_req), .restore_req(restore_req),
      .rett_req(rett_req), .wrsr_req(wrsr_req), .wrwim_req(wrwim_req), .wr_data(wr_data),
      .cwp(cwp), .wim(wim), .status_word(status_word), .reg_base(reg_base),
      .trap_pulse(trap_pulse), .trap_code(trap_code)
   );

   always #4 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference model state
   int m_cwp = 0, m_wim = 0, m_et = 0, m_ps = 0, m_s = 1, m_pil = 0, m_ef = 0, m_icc = 0;
   int m_trap = 0, m_code = 0;
   string tag = "R1";

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int exp_status();
      return (int'(VER) << 24) | (m_icc << 20) | (m_ef << 12) | (m_pil << 8) |
             (m_s << 7) | (m_ps << 6) | (m_et << 5) | m_cwp;
   endfunction

   task automatic compare_all();
      chk(tag, "cwp", int'(cwp), m_cwp);
      chk(tag, "status", int'(status_word), exp_status());
      chk(tag, "trap_code", int'(trap_code), m_code);
      chk("R10", "reg_base", int'(reg_base), m_cwp * 16);
      chk("R12", "wim", int'(wim), m_wim);
      chk("R13", "trap_pulse", int'(trap_pulse), m_trap);
   endtask

   task automatic model_step(bit sv, bit rs, bit rt, bit wr, bit ww, logic [31:0] d);
      int n;
      m_trap = 0;
      m_code = 0;
      if (sv) begin
         n = m_cwp - 1;
         if (n < 0) n += N;
         if ((m_wim >> n) & 1) begin m_trap = 1; m_code = 1; tag = "R4"; end
         else begin m_cwp = n; tag = "R2"; end
      end else if (rs) begin
         n = m_cwp + 1;
         if (n >= N) n -= N;
         if ((m_wim >> n) & 1) begin m_trap = 1; m_code = 2; tag = "R5"; end
         else begin m_cwp = n; tag = "R3"; end
      end else if (rt) begin
         n = m_cwp + 1;
         if (n >= N) n -= N;
         if (m_et == 1) begin m_trap = 1; m_code = 3; tag = "R6"; end
         else if ((m_wim >> n) & 1) begin m_trap = 1; m_code = 2; tag = "R7"; end
         else begin m_cwp = n; m_et = 1; m_s = m_ps; tag = "R7"; end
      end else if (wr) begin
         if (int'(d[4:0]) >= N) begin m_trap = 1; m_code = 3; tag = "R8"; end
         else begin
            m_cwp = int'(d[4:0]); m_et = int'(d[5]); m_ps = int'(d[6]); m_s = int'(d[7]);
            m_pil = int'(d[11:8]); m_ef = int'(d[12]); m_icc = int'(d[23:20]);
            tag = "R9";
         end
      end else if (ww) begin
         m_wim = int'(d) & ((1 << N) - 1);
         tag = "R12";
      end else begin
         tag = "R13";
      end
      if (int'(sv) + int'(rs) + int'(rt) + int'(wr) + int'(ww) > 1) tag = "R11";
   endtask

   task automatic cycle(bit sv, bit rs, bit rt, bit wr, bit ww, logic [31:0] d);
      @(negedge clk);
      compare_all();
      save_req = sv; restore_req = rs; rett_req = rt; wrsr_req = wr; wrwim_req = ww;
      wr_data = d;
      model_step(sv, rs, rt, wr, ww, d);
   endtask

   task automatic idle();
      cycle(0, 0, 0, 0, 0, 32'h0);
   endtask

   initial begin
      logic [31:0] lf;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state compared on the first cycle
      idle();
      // R2: walk backwards around the whole ring, wrapping 0 -> N-1
      for (int i = 0; i < N + 2; i++) cycle(1, 0, 0, 0, 0, 32'h0);
      // R3: walk forwards, wrapping N-1 -> 0
      for (int i = 0; i < N + 3; i++) cycle(0, 1, 0, 0, 0, 32'h0);
      // R12: mark window 1 invalid, upper data bits ignored
      cycle(0, 0, 0, 0, 1, 32'hFFFF_FFC2);
      // R4: saves until window 1 blocks
      for (int i = 0; i < N; i++) cycle(1, 0, 0, 0, 0, 32'h0);
      // R5: restores until window 1 blocks
      for (int i = 0; i < N; i++) cycle(0, 1, 0, 0, 0, 32'h0);
      cycle(0, 0, 0, 0, 1, 32'h0);
      // R9: legal status write, all fields set, ET=1
      cycle(0, 0, 0, 1, 0, 32'hFFFF_FFE3);
      // R6: return-from-trap with ET=1
      cycle(0, 0, 1, 0, 0, 32'h0);
      // R7: ET=0, PS=1, S=0, pointer 4 -> 5
      cycle(0, 0, 0, 1, 0, 32'h0050_0A44);
      cycle(0, 0, 1, 0, 0, 32'h0);
      // R7: underflow path, mark window 0 invalid, clear ET
      cycle(0, 0, 0, 0, 1, 32'h0000_0001);
      cycle(0, 0, 0, 1, 0, 32'h0000_0045);
      cycle(0, 0, 1, 0, 0, 32'h0);
      // R8: out-of-range pointer fields
      cycle(0, 0, 0, 1, 0, 32'h00F0_1FE6);
      cycle(0, 0, 0, 1, 0, 32'h0000_001F);
      cycle(0, 0, 0, 0, 1, 32'h0);
      // R11: simultaneous strobes, lowest-numbered wins
      cycle(1, 1, 1, 1, 1, 32'h0000_0003);
      cycle(0, 1, 1, 1, 0, 32'h0000_0002);
      cycle(0, 0, 1, 1, 1, 32'h0000_0001);
      cycle(0, 0, 0, 1, 1, 32'h0000_003F);
      idle();
      // random run
      lf = 32'h1ACE_B00C;
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] d;
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         d = lf;
         if (lf[11]) d[4:0] = {2'b00, lf[10:8]};
         if (lf[15:13] == 3'd7) d = d & 32'hFFFF_FFDF;
         case (lf[2:0])
            3'd0: cycle(1, 0, 0, 0, 0, d);
            3'd1: cycle(0, 1, 0, 0, 0, d);
            3'd2: cycle(0, 0, 1, 0, 0, d);
            3'd3: cycle(0, 0, 0, 1, 0, d);
            3'd4: cycle(0, 0, 0, 0, lf[20] & lf[21], d);
            3'd5: cycle(lf[3], lf[4], lf[5], lf[6], lf[7], d);
            default: idle();
         endcase
      end
      idle();
      idle();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule